// File: doc/BRIEF.md
# Framed Serial Transmitter with Qualified Sync Insertion

This block turns a 10-bit parallel word, presented once per word period, into a framed serial bit stream running at twelve bits per word. It runs on a bit-rate clock. A one-cycle word strobe marks the first bit of every frame. The word clock is not a separate clock input. Its rising edge is taken to coincide with the strobe, and its falling edge falls half a period (six bit clocks) later. A select input picks which of these two instants captures the parallel input into the block's input register. The captured word goes out in the frame that starts at the next strobe.

Two sync request inputs are ORed together. Once the combined request has been seen high at five consecutive strobes, each new frame carries a fixed sync symbol in place of data. This continues for as long as the request stays high. An output-enable input and an active-low power-down input drive a tri-state enable for the serial pin. Power-down also clears all internal state.

Top module: `fser_tx`

## Requirements
- R1: With `edge_rise`=1, `din` is captured at the bit-clock edge where `word_stb` is sampled high. The captured value is sent in the frame that starts at the following strobe.
- R2: With `edge_rise`=0, `din` is captured at the sixth bit-clock edge after the strobe edge, which is half of a 12-bit word period. The captured value is sent in the frame that starts at the next strobe.
- R3: A data frame is 12 bits sent in this order: a start bit 1, then data bits 0 through 9 (least significant first), then a stop bit 0. Bit 0 of the frame appears on `sdat` in the cycle after the strobe edge, and each later bit follows one cycle after the previous one.
- R4: A high level on either `sync_a` or `sync_b` forms the combined sync request.
- R5: Suppose the combined request is sampled high at five consecutive strobe edges. The frame started at the fifth of those edges is the sync symbol: six 1 bits followed by six 0 bits, sent first-to-last in that order.
- R6: Sync frames repeat at every strobe while the request remains high, because the qualification count saturates. Any cycle with the request low clears the count, so qualification starts again from zero.
- R7: The choice between sync and data is made only at a strobe edge. A change of the request in the middle of a frame leaves that frame unchanged.
- R8: While `out_en` is 0, `sdat_oe` is 0. Framing and capture carry on unaffected.
- R9: While `pwr_n` is 0, `sdat_oe` and `sdat` are 0 and the input register and the sync count are cleared. The first frame after release carries data 0, and sync needs five new qualifying strobes.
- R10: During and right after reset, `sdat` is 0 and `sdat_oe` equals `out_en` AND `pwr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, 12 cycles per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle pulse marking the start of each frame |
| edge_rise | input | 1 | 1: capture at word-clock rising instant; 0: at falling instant |
| din | input | 10 | Parallel data word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| out_en | input | 1 | Serial output enable, active high |
| pwr_n | input | 1 | Power-down, active low |
| sdat | output | 1 | Serial data |
| sdat_oe | output | 1 | Tri-state enable for the serial pin |

## Verification
The assertions check a set of rules on every cycle:
- Output gating by each of the two controls.
- The zero output one cycle into power-down.
- The start bit of 1 after every strobe.
- The clearing of the sync count on a low request, and its ceiling.

Only the bench's scenarios can show the rest. That includes which instant captures the data, and the full 12-bit content of data and sync frames. It also includes the five-strobe qualification with gaps, the OR of the two sources, the frame-boundary rule for changes mid-frame, and the zeroed state after power-down.

// File: rtl/fser_pkg.sv
package fser_pkg;
  typedef enum logic {
    CAP_FALL = 1'b0,
    CAP_RISE = 1'b1
  } cap_edge_e;

  localparam int unsigned WORD_W_DEF   = 10;
  localparam int unsigned SYNC_HLD_DEF = 5;
endpackage

// File: rtl/fser_capture.sv
module fser_capture #(
  parameter int unsigned DW    = 10,
  parameter int unsigned FRAME = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          stb,
  input  logic          edge_rise,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] word_q
);
  import fser_pkg::*;
  localparam int unsigned PW   = $clog2(FRAME);
  localparam int unsigned HALF = FRAME / 2;

  logic [PW-1:0] phase;
  logic          cap;
  cap_edge_e     sel;

  assign sel = cap_edge_e'(edge_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       phase <= '0;
    else if (!pwr_n || stb)           phase <= '0;
    else if (phase != PW'(FRAME - 1)) phase <= phase + 1'b1;
  end

  always_comb begin
    if (sel == CAP_RISE) cap = stb;
    else                 cap = !stb && (phase == PW'(HALF - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (!pwr_n) word_q <= '0;
    else if (cap)    word_q <= din;
  end
endmodule

// File: rtl/fser_syncq.sv
module fser_syncq #(
  parameter int unsigned THR = 5,
  parameter int unsigned CW  = $clog2(THR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          stb,
  input  logic          sreq,
  output logic          send_sync,
  output logic [CW-1:0] qcnt
);
  localparam logic [CW-1:0] TOP = CW'(THR - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 qcnt <= '0;
    else if (!pwr_n || !sreq)   qcnt <= '0;
    else if (stb && qcnt < TOP) qcnt <= qcnt + 1'b1;
  end

  assign send_sync = sreq && (qcnt == TOP);
endmodule

// File: rtl/fser_shift.sv
module fser_shift #(
  parameter int unsigned DW    = 10,
  parameter int unsigned FRAME = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          stb,
  input  logic          send_sync,
  input  logic [DW-1:0] word,
  output logic          sdat
);
  logic [FRAME-1:0] sync_fr;
  logic [FRAME-1:0] data_fr;
  logic [FRAME-1:0] sh;

  for (genvar k = 0; k < FRAME; k++) begin : g_sync
    assign sync_fr[k] = (k < FRAME / 2);
  end

  assign data_fr = {1'b0, word, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (!pwr_n) sh <= '0;
    else if (stb)    sh <= send_sync ? sync_fr : data_fr;
    else             sh <= {1'b0, sh[FRAME-1:1]};
  end

  assign sdat = sh[0];
endmodule

// File: rtl/fser_tx.sv
module fser_tx #(
  parameter int unsigned DW        = fser_pkg::WORD_W_DEF,
  parameter int unsigned SYNC_HOLD = fser_pkg::SYNC_HLD_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_stb,
  input  logic          edge_rise,
  input  logic [DW-1:0] din,
  input  logic          sync_a,
  input  logic          sync_b,
  input  logic          out_en,
  input  logic          pwr_n,
  output logic          sdat,
  output logic          sdat_oe
);
  localparam int unsigned FRAME = DW + 2;
  localparam int unsigned CW    = $clog2(SYNC_HOLD);

  logic [DW-1:0] word_q;
  logic          sreq;
  logic          send_sync;
  logic [CW-1:0] q_cnt;

  assign sreq    = sync_a | sync_b;
  assign sdat_oe = out_en & pwr_n;

  fser_capture #(.DW(DW), .FRAME(FRAME)) u_cap (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .stb(word_stb),
    .edge_rise(edge_rise), .din(din), .word_q(word_q)
  );

  fser_syncq #(.THR(SYNC_HOLD), .CW(CW)) u_sq (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .stb(word_stb),
    .sreq(sreq), .send_sync(send_sync), .qcnt(q_cnt)
  );

  fser_shift #(.DW(DW), .FRAME(FRAME)) u_sh (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .stb(word_stb),
    .send_sync(send_sync), .word(word_q), .sdat(sdat)
  );
endmodule

// File: rtl/fser_tx_chk.sv
module fser_tx_chk #(
  parameter int unsigned THR = 5,
  parameter int unsigned CW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_stb,
  input logic          sync_a,
  input logic          sync_b,
  input logic          out_en,
  input logic          pwr_n,
  input logic          sdat,
  input logic          sdat_oe,
  input logic [CW-1:0] qcnt
);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !sdat_oe);

  // R9
  pd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |-> !sdat_oe);

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !sdat);

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && word_stb) |=> sdat);

  // R6
  qual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_a || sync_b) |=> (qcnt == '0));

  // R6
  qual_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= CW'(THR - 1));
endmodule

bind fser_tx fser_tx_chk #(.THR(SYNC_HOLD), .CW($clog2(SYNC_HOLD))) u_chk (
  .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .sync_a(sync_a),
  .sync_b(sync_b), .out_en(out_en), .pwr_n(pwr_n), .sdat(sdat),
  .sdat_oe(sdat_oe), .qcnt(q_cnt)
);

// File: tb/sim_fser_tx.sv
`timescale 1ns/1ps
module sim_fser_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_stb = 1'b0;
  logic       edge_rise = 1'b1;
  logic [9:0] din = '0;
  logic       sync_a = 1'b0;
  logic       sync_b = 1'b0;
  logic       out_en = 1'b1;
  logic       pwr_n = 1'b1;
  logic       sdat;
  logic       sdat_oe;

  int total = 0;
  int fails = 0;
  int run = 0;
  logic [9:0] prev = '0;
  localparam logic [11:0] SYNC_FR = 12'b000000_111111;

  always #4 clk = ~clk;

  fser_tx u0 (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .edge_rise(edge_rise),
    .din(din), .sync_a(sync_a), .sync_b(sync_b), .out_en(out_en),
    .pwr_n(pwr_n), .sdat(sdat), .sdat_oe(sdat_oe)
  );

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // one word period; stimulus set at negedges, outputs sampled at negedges
  task automatic step(input string tag, input logic [9:0] a, input logic [9:0] b,
                      input logic sa, input logic sb, input logic chg, input logic mid);
    logic [11:0] got;
    logic [11:0] exp;
    logic        is_sync;
    logic        oe_exp;
    int          oe_bad = 0;
    word_stb = 1'b1;
    din = a;
    sync_a = sa;
    sync_b = sb;
    oe_exp = out_en & pwr_n;
    if (!pwr_n) begin
      exp = '0; run = 0; prev = '0;
    end else begin
      run = (sa | sb) ? ((run < 5) ? run + 1 : 5) : 0;
      is_sync = (sa | sb) && (run >= 5);
      exp = is_sync ? SYNC_FR : {1'b0, prev, 1'b1};
      prev = edge_rise ? a : b;
      if (chg && !mid) run = 0;
    end
    for (int j = 0; j < 12; j++) begin
      @(posedge clk);
      @(negedge clk);
      got[j] = sdat;
      if (sdat_oe !== oe_exp) oe_bad++;
      if (j == 0) word_stb = 1'b0;
      if (j == 5) begin
        din = b;
        if (chg) begin sync_a = mid; sync_b = 1'b0; end
      end
    end
    chk(tag, got, exp);
    total++;
    if (oe_bad != 0) begin
      fails++;
      $display("FAIL %s oe: actual mismatches %0d expected %b", tag, oe_bad, oe_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {10'd0, sdat_oe, sdat}, {10'd0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {10'd0, sdat_oe, sdat}, {10'd0, 1'b1, 1'b0});

    // R1 rising-instant capture, R3 frame format, full word sweep
    edge_rise = 1'b1;
    for (int i = 0; i < 1024; i++) step("R1 R3 rise", 10'(i), ~10'(i), 0, 0, 0, 0);
    // R2 falling-instant capture sweep
    edge_rise = 1'b0;
    for (int i = 0; i < 1024; i++) step("R2 R3 fall", 10'(i), ~10'(i), 0, 0, 0, 0);
    edge_rise = 1'b1;

    // R5 R6 qualification and continuation, source a only
    for (int i = 0; i < 7; i++) step("R5 R6 sync_a", 10'h155 + 10'(i), 10'h0, 1, 0, 0, 0);
    step("R6 clear", 10'h2aa, 10'h0, 0, 0, 0, 0);
    // R4 alternating sources keep the combined request high
    for (int i = 0; i < 6; i++) step("R4 or", 10'(i * 37), 10'h0, i[0], ~i[0], 0, 0);
    step("R6 clear2", 10'h0f0, 10'h0, 0, 0, 0, 0);
    // R6 a gap restarts qualification
    for (int i = 0; i < 4; i++) step("R6 gap pre", 10'(i + 3), 10'h0, 0, 1, 0, 0);
    step("R6 gap", 10'h111, 10'h0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R5 gap post", 10'(i + 9), 10'h0, 0, 1, 0, 0);
    // R7 request drop mid-frame leaves the sync frame whole
    step("R7 drop mid", 10'h321, 10'h0, 0, 1, 1, 0);
    step("R7 after drop", 10'h123, 10'h0, 1, 0, 0, 0);
    step("R7 low", 10'h0aa, 10'h0, 0, 0, 0, 0);
    // R7 request rise mid-frame leaves the data frame whole
    step("R7 rise mid", 10'h3c3, 10'h0, 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) step("R7 R5 after rise", 10'(i + 50), 10'h0, 1, 0, 0, 0);
    step("R7 low2", 10'h0, 10'h0, 0, 0, 0, 0);

    // R8 output disabled, framing continues
    out_en = 1'b0;
    for (int i = 0; i < 3; i++) step("R8 oe low", 10'(i * 101), 10'h0, 0, 0, 0, 0);
    out_en = 1'b1;
    step("R8 oe back", 10'h2f1, 10'h0, 0, 0, 0, 0);

    // R9 power-down with sync held throughout
    for (int i = 0; i < 3; i++) step("R9 pre", 10'h1e, 10'h0, 1, 0, 0, 0);
    pwr_n = 1'b0;
    for (int i = 0; i < 2; i++) step("R9 pd", 10'h3ff, 10'h3ff, 1, 0, 0, 0);
    pwr_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R9 release", 10'h1b + 10'(i), 10'h0, 1, 0, 0, 0);
    step("R9 end", 10'h0, 10'h0, 0, 0, 0, 0);

    finish_up();
  end
endmodule